// File: doc/BRIEF.md
# Variable-Aspect Dual-Port SRAM

A 4-Kbit embedded memory with one write port and one read port. The two ports choose their width and depth separately from six aspect ratios, so a word written at one width can be read back at another. The array is held as 512 rows of 9 bits. The 1-, 2- and 4-bit modes use only the eight low bits of each row. The 18- and 36-bit modes span two or four consecutive rows.

A serial loader can fill all 4096 data bits after reset, so the block can serve as a preloaded lookup table. While loading, it shuts out the normal write port and raises a ready flag once the last bit is stored. To build a deeper memory, several blocks share both ports. Each block compares a small address field above the mode's own address range against its block number and gates its port select. The read data of a block that is not selected is zero, so the outputs of all blocks can be ORed together.

Top module: `vaspect_sram`

## Requirements
- R1: Mode codes on `wr_mode`/`rd_mode` are 0=4096x1, 1=2048x2, 2=1024x4, 3=512x9, 4=256x18, 5=128x36. The mode uses the low 12, 11, 10, 9, 8 or 7 address bits respectively.
- R2: Storage is 512 rows of 9 bits. In modes 0-2, element n of width w (1, 2 or 4) covers row (n*w)/8, bits (n*w)%8 upward. So the bit index within the 8 data bits of each row is address times width plus lane offset. A 9-bit row written in mode 3 reads back bit by bit in mode 0 at addresses 8*row..8*row+7.
- R3: A read registered while `rd_en` is high presents its data one cycle later. The data then holds while `rd_en` stays low.
- R4: A read of a location written in the same cycle returns the data held before that write.
- R5: In mode 4, address a covers row 2a on bits 8:0 and row 2a+1 on bits 17:9. In mode 5, address a covers rows 4a..4a+3, the lowest row on bits 8:0.
- R6: A write or read takes effect only when its port select is high and the CASC_BITS address bits just above the mode's field equal BLK_ID. A rejected write changes nothing, and a rejected read returns all zeros.
- R7: While `init_en` is high and loading is not complete, each cycle stores `init_bit` at mode-0 address 0, 1, 2, ... in turn. `init_ready` rises on the cycle after bit 4095 is stored, and not before.
- R8: While loading is in progress, `wr_en` has no effect.
- R9: `init_ready` is low after reset and, once high, stays high until the next reset.
- R10: Output bits above the read width are zero. Mode codes 6 and 7 write nothing and read zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init_en | input | 1 | Serial preload enable |
| init_bit | input | 1 | Serial preload data bit |
| init_ready | output | 1 | All 4096 preload bits stored |
| wr_en | input | 1 | Write strobe |
| wr_cs | input | 1 | Write port select for cascading |
| wr_mode | input | 3 | Write aspect code |
| wr_addr | input | 12+CASC_BITS | Write address; upper bits pick the block |
| wr_data | input | 36 | Write data, right-aligned |
| rd_en | input | 1 | Read strobe |
| rd_cs | input | 1 | Read port select for cascading |
| rd_mode | input | 3 | Read aspect code |
| rd_addr | input | 12+CASC_BITS | Read address; upper bits pick the block |
| rd_data | output | 36 | Read data, right-aligned, zero when not selected |

## Verification
The assertions check on every cycle the rules that hold whatever the array contains. An idle read port holds its output, and a deselected read gives zeros. A 1-bit read leaves the upper output bits at zero. The ready flag only rises during loading and never falls. Only the bench's scenarios can show that the data is correct. This covers the bit mapping when one width is written and another is read, the lane order of the wide modes, and old data on a same-cycle read and write. It also covers the preloaded pattern, the writes that are shut out during loading and the writes rejected by cascade decode.

// File: rtl/vsram_pkg.sv
package vsram_pkg;
  localparam int BANKS     = 4;
  localparam int BANK_ROWS = 128;
  localparam int ROW_W     = 9;
  localparam int DATA_W    = BANKS * ROW_W;
  localparam int LOC_AW    = 12;
  localparam int TOTAL_BITS = 1 << LOC_AW;
  localparam int BROW_AW   = $clog2(BANK_ROWS);

  typedef enum logic [2:0] {
    AR_X1  = 3'd0,
    AR_X2  = 3'd1,
    AR_X4  = 3'd2,
    AR_X9  = 3'd3,
    AR_X18 = 3'd4,
    AR_X36 = 3'd5
  } aspect_e;

  // shift from a mode's address down to the common bank row index
  function automatic logic [2:0] row_shift(input logic [2:0] m);
    case (m)
      AR_X1:   return 3'd5;
      AR_X2:   return 3'd4;
      AR_X4:   return 3'd3;
      AR_X9:   return 3'd2;
      AR_X18:  return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // number of address bits that a mode uses inside one block
  function automatic logic [3:0] field_w(input logic [2:0] m);
    case (m)
      AR_X1:   return 4'd12;
      AR_X2:   return 4'd11;
      AR_X4:   return 4'd10;
      AR_X9:   return 4'd9;
      AR_X18:  return 4'd8;
      default: return 4'd7;
    endcase
  endfunction

  function automatic logic mode_ok(input logic [2:0] m);
    return m <= 3'd5;
  endfunction
endpackage

// File: rtl/vsram_bank.sv
module vsram_bank #(
  parameter int ROWS = 128,
  parameter int W    = 9,
  localparam int RA  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RA-1:0] waddr,
  input  logic [W-1:0]  wmask,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [RA-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [ROWS];
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
    end
    if (re) begin
      rdata_q <= mem[raddr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/vsram_wr_map.sv
module vsram_wr_map
  import vsram_pkg::*;
(
  input  logic                          en,
  input  logic [2:0]                    mode,
  input  logic [LOC_AW-1:0]             addr,
  input  logic [DATA_W-1:0]             data,
  output logic [BROW_AW-1:0]            row,
  output logic [BANKS-1:0]              we,
  output logic [BANKS-1:0][ROW_W-1:0]   mask,
  output logic [BANKS-1:0][ROW_W-1:0]   wd
);
  logic [LOC_AW-1:0] shifted;

  always_comb begin
    shifted = addr >> row_shift(mode);
    row     = shifted[BROW_AW-1:0];
    for (int i = 0; i < BANKS; i++) begin
      we[i]   = 1'b0;
      mask[i] = '0;
      wd[i]   = '0;
    end
    case (mode)
      AR_X1: begin
        for (int i = 0; i < BANKS; i++) begin
          wd[i]   = ROW_W'(data[0]) << addr[2:0];
          mask[i] = ROW_W'(1) << addr[2:0];
          we[i]   = en && (addr[4:3] == 2'(i));
        end
      end
      AR_X2: begin
        for (int i = 0; i < BANKS; i++) begin
          wd[i]   = ROW_W'(data[1:0]) << {addr[1:0], 1'b0};
          mask[i] = ROW_W'(3) << {addr[1:0], 1'b0};
          we[i]   = en && (addr[3:2] == 2'(i));
        end
      end
      AR_X4: begin
        for (int i = 0; i < BANKS; i++) begin
          wd[i]   = ROW_W'(data[3:0]) << {addr[0], 2'b00};
          mask[i] = ROW_W'(15) << {addr[0], 2'b00};
          we[i]   = en && (addr[2:1] == 2'(i));
        end
      end
      AR_X9: begin
        for (int i = 0; i < BANKS; i++) begin
          wd[i]   = data[ROW_W-1:0];
          mask[i] = '1;
          we[i]   = en && (addr[1:0] == 2'(i));
        end
      end
      AR_X18: begin
        for (int i = 0; i < BANKS; i++) begin
          wd[i]   = data[ROW_W*(i%2) +: ROW_W];
          mask[i] = '1;
          we[i]   = en && (1'(i/2) == addr[0]);
        end
      end
      AR_X36: begin
        for (int i = 0; i < BANKS; i++) begin
          wd[i]   = data[ROW_W*i +: ROW_W];
          mask[i] = '1;
          we[i]   = en;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vsram_rd_sel.sv
module vsram_rd_sel
  import vsram_pkg::*;
(
  input  logic                        hit,
  input  logic [2:0]                  mode,
  input  logic [4:0]                  lo,
  input  logic [BANKS-1:0][ROW_W-1:0] q,
  output logic [DATA_W-1:0]           data
);
  always_comb begin
    data = '0;
    if (hit) begin
      case (mode)
        AR_X1:  data = DATA_W'(q[lo[4:3]][lo[2:0]]);
        AR_X2:  data = DATA_W'(q[lo[3:2]][{lo[1:0], 1'b0} +: 2]);
        AR_X4:  data = DATA_W'(q[lo[2:1]][{lo[0], 2'b00} +: 4]);
        AR_X9:  data = DATA_W'(q[lo[1:0]]);
        AR_X18: data = lo[0] ? DATA_W'({q[3], q[2]}) : DATA_W'({q[1], q[0]});
        AR_X36: data = {q[3], q[2], q[1], q[0]};
        default: data = '0;
      endcase
    end
  end
endmodule

// File: rtl/vsram_init.sv
module vsram_init #(
  parameter int TOTAL = 4096,
  localparam int PW   = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_en,
  output logic          active,
  output logic [PW-1:0] ptr,
  output logic          ready
);
  logic [PW-1:0] ptr_q, ptr_d;
  logic          rdy_q, rdy_d;

  assign active = init_en && !rdy_q;

  always_comb begin
    ptr_d = ptr_q;
    rdy_d = rdy_q;
    if (active) begin
      ptr_d = ptr_q + 1'b1;
      if (ptr_q == PW'(TOTAL - 1)) rdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      rdy_q <= rdy_d;
    end
  end

  assign ptr   = ptr_q;
  assign ready = rdy_q;
endmodule

// File: rtl/vaspect_sram.sv
module vaspect_sram
  import vsram_pkg::*;
#(
  parameter int CASC_BITS = 2,
  parameter int BLK_ID    = 0,
  localparam int ADDR_W   = LOC_AW + CASC_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_en,
  input  logic              init_bit,
  output logic              init_ready,
  input  logic              wr_en,
  input  logic              wr_cs,
  input  logic [2:0]        wr_mode,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_cs,
  input  logic [2:0]        rd_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  function automatic logic blk_hit(input logic [ADDR_W-1:0] a, input logic [2:0] m);
    logic [ADDR_W-1:0] up;
    up = a >> field_w(m);
    return up[CASC_BITS-1:0] == CASC_BITS'(BLK_ID);
  endfunction

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  // serial preload
  logic              ld_active;
  logic [LOC_AW-1:0] ld_ptr;
  vsram_init #(.TOTAL(TOTAL_BITS)) u_init (
    .clk(clk), .rst_n(srst_n), .init_en(init_en),
    .active(ld_active), .ptr(ld_ptr), .ready(init_ready)
  );

  // write port selection: the loader takes over as a 1-bit writer
  logic              w_en;
  logic [2:0]        w_mode;
  logic [LOC_AW-1:0] w_addr;
  logic [DATA_W-1:0] w_data;
  always_comb begin
    if (ld_active) begin
      w_en   = 1'b1;
      w_mode = AR_X1;
      w_addr = ld_ptr;
      w_data = DATA_W'(init_bit);
    end else begin
      w_en   = wr_en && wr_cs && mode_ok(wr_mode) && blk_hit(wr_addr, wr_mode);
      w_mode = wr_mode;
      w_addr = wr_addr[LOC_AW-1:0];
      w_data = wr_data;
    end
  end

  logic [BROW_AW-1:0]            bk_wrow;
  logic [BANKS-1:0]              bk_we;
  logic [BANKS-1:0][ROW_W-1:0]   bk_mask, bk_wd, bk_q;

  vsram_wr_map u_wmap (
    .en(w_en), .mode(w_mode), .addr(w_addr), .data(w_data),
    .row(bk_wrow), .we(bk_we), .mask(bk_mask), .wd(bk_wd)
  );

  // read address decode
  logic [LOC_AW-1:0]  r_shift;
  logic [BROW_AW-1:0] bk_rrow;
  always_comb begin
    r_shift = rd_addr[LOC_AW-1:0] >> row_shift(rd_mode);
    bk_rrow = r_shift[BROW_AW-1:0];
  end

  genvar b;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      vsram_bank #(.ROWS(BANK_ROWS), .W(ROW_W)) u_bank (
        .clk(clk), .we(bk_we[b]), .waddr(bk_wrow),
        .wmask(bk_mask[b]), .wdata(bk_wd[b]),
        .re(rd_en), .raddr(bk_rrow), .rdata(bk_q[b])
      );
    end
  endgenerate

  // read-side lane state, captured alongside the bank rows
  logic [2:0] rmode_q, rmode_d;
  logic [4:0] rlo_q, rlo_d;
  logic       rhit_q, rhit_d;
  always_comb begin
    rmode_d = rmode_q;
    rlo_d   = rlo_q;
    rhit_d  = rhit_q;
    if (rd_en) begin
      rmode_d = rd_mode;
      rlo_d   = rd_addr[4:0];
      rhit_d  = rd_cs && mode_ok(rd_mode) && blk_hit(rd_addr, rd_mode);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rmode_q <= '0;
      rlo_q   <= '0;
      rhit_q  <= 1'b0;
    end else begin
      rmode_q <= rmode_d;
      rlo_q   <= rlo_d;
      rhit_q  <= rhit_d;
    end
  end

  vsram_rd_sel u_rsel (
    .hit(rhit_q), .mode(rmode_q), .lo(rlo_q), .q(bk_q), .data(rd_data)
  );
endmodule

// File: rtl/vsram_chk.sv
module vsram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        init_en,
  input logic        init_ready,
  input logic        rd_en,
  input logic        rd_cs,
  input logic [2:0]  rd_mode,
  input logic [35:0] rd_data
);
  // R3: an idle read port keeps its output
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R6: a deselected read gives zeros
  p_unsel_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_cs) |=> (rd_data == '0));

  // R9: ready never falls outside reset
  p_ready_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_ready |=> init_ready);

  // R7: ready can only rise while loading is requested
  p_ready_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_ready) |-> $past(init_en));

  // R10: 1-bit reads leave the upper bits clear
  p_x1_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_mode == 3'd0) |=> (rd_data[35:1] == '0));
endmodule

bind vaspect_sram vsram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_en(init_en), .init_ready(init_ready),
  .rd_en(rd_en), .rd_cs(rd_cs), .rd_mode(rd_mode), .rd_data(rd_data)
);

// File: tb/tb_vaspect_sram.sv
module tb_vaspect_sram;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        init_en, init_bit, init_ready;
  logic        wr_en, wr_cs, rd_en, rd_cs;
  logic [2:0]  wr_mode, rd_mode;
  logic [13:0] wr_addr, rd_addr;
  logic [35:0] wr_data, rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  logic [35:0] got;

  always #2 clk = ~clk;

  vaspect_sram dut (
    .clk(clk), .rst_n(rst_n), .init_en(init_en), .init_bit(init_bit),
    .init_ready(init_ready), .wr_en(wr_en), .wr_cs(wr_cs), .wr_mode(wr_mode),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_cs(rd_cs),
    .rd_mode(rd_mode), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [2:0]  wm;
    logic [13:0] wa;
    logic [35:0] wd;
    logic [2:0]  rm;
    logic [13:0] ra;
    logic [35:0] ex;
  } vec_t;

  // preload pattern: bit i = i[0], so each data byte reads 0xAA
  localparam vec_t VECS [10] = '{
    '{3'd3, 14'd10,  36'h1A5, 3'd3, 14'd10,  36'h1A5},                      // R1
    '{3'd3, 14'd11,  36'h0C3, 3'd0, 14'd89,  36'h1},                        // R2
    '{3'd3, 14'd12,  36'h05A, 3'd2, 14'd25,  36'h5},                        // R2
    '{3'd5, 14'd4,   {9'h111, 9'h0EE, 9'h155, 9'h0AA}, 3'd3, 14'd18, 36'h0EE}, // R5
    '{3'd4, 14'd10,  {18'h0, 9'h033, 9'h1CC}, 3'd3, 14'd21, 36'h033},          // R5
    '{3'd0, 14'd246, 36'h1,   3'd2, 14'd61,  36'hE},                        // R2
    '{3'd1, 14'd126, 36'h1,   3'd2, 14'd63,  36'h9},                        // R2
    '{3'd2, 14'd64,  36'hC,   3'd1, 14'd129, 36'h3},                        // R2
    '{3'd5, 14'd9,   {9'h1FF, 9'h000, 9'h1FF, 9'h000}, 3'd4, 14'd19, 36'h3FE00}, // R5
    '{3'd4, 14'd20,  {18'h0, 9'h0F0, 9'h10F}, 3'd0, 14'd332, 36'h1}            // R5
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] m, input logic [13:0] a, input logic [35:0] d, input logic cs);
    wr_en = 1'b1; wr_cs = cs; wr_mode = m; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] m, input logic [13:0] a, input logic cs, output logic [35:0] q);
    rd_en = 1'b1; rd_cs = cs; rd_mode = m; rd_addr = a;
    tick();
    rd_en = 1'b0;
    q = rd_data;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; init_en = 1'b0; init_bit = 1'b0;
    wr_en = 1'b0; wr_cs = 1'b0; wr_mode = '0; wr_addr = '0; wr_data = '0;
    rd_en = 1'b0; rd_cs = 1'b0; rd_mode = '0; rd_addr = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    check("R9 ready low after reset", 36'(init_ready), 36'h0);
    check("R3 read data zero after reset", rd_data, 36'h0);

    // preload with competing writes that must be ignored (R8)
    for (int i = 0; i < 4096; i++) begin
      init_en = 1'b1; init_bit = i[0];
      wr_en = 1'b1; wr_cs = 1'b1; wr_mode = 3'd3;
      wr_addr = 14'(i % 512); wr_data = '0;
      tick();
      if (i == 4094) check("R7 ready not before last bit", 36'(init_ready), 36'h0);
    end
    check("R7 ready after 4096 bits", 36'(init_ready), 36'h1);
    init_en = 1'b0; wr_en = 1'b0;

    do_rd(3'd2, 14'd0, 1'b1, got);
    check("R8 writes ignored during load", got, 36'hA);
    do_rd(3'd0, 14'd4095, 1'b1, got);
    check("R7 last preload bit", got, 36'h1);
    do_rd(3'd0, 14'd4094, 1'b1, got);
    check("R7 preload bit 4094", got, 36'h0);

    for (int k = 0; k < 10; k++) begin
      do_wr(VECS[k].wm, VECS[k].wa, VECS[k].wd, 1'b1);
      do_rd(VECS[k].rm, VECS[k].ra, 1'b1, got);
      check($sformatf("R1 R2 R5 vector %0d", k), got, VECS[k].ex);
    end

    // R4: same-cycle read and write returns old data
    do_wr(3'd2, 14'd100, 36'h5, 1'b1);
    wr_en = 1'b1; wr_cs = 1'b1; wr_mode = 3'd2; wr_addr = 14'd100; wr_data = 36'h3;
    rd_en = 1'b1; rd_cs = 1'b1; rd_mode = 3'd2; rd_addr = 14'd100;
    tick();
    wr_en = 1'b0; rd_en = 1'b0;
    check("R4 old data on collision", rd_data, 36'h5);
    do_rd(3'd2, 14'd100, 1'b1, got);
    check("R4 new data next read", got, 36'h3);

    // R3: output holds while idle
    rd_mode = 3'd5; rd_addr = 14'd0;
    tick();
    check("R3 output holds while idle", rd_data, 36'h3);

    // R6: cascade decode
    do_wr(3'd3, 14'((1 << 9) | 60), 36'h0FF, 1'b1);
    do_rd(3'd2, 14'd120, 1'b1, got);
    check("R6 write to other block ignored", got, 36'hA);
    do_wr(3'd3, 14'd61, 36'h0FF, 1'b0);
    do_rd(3'd2, 14'd122, 1'b1, got);
    check("R6 write without select ignored", got, 36'hA);
    do_rd(3'd3, 14'd10, 1'b0, got);
    check("R6 read without select is zero", got, 36'h0);
    do_rd(3'd3, 14'((1 << 9) | 10), 1'b1, got);
    check("R6 read of other block is zero", got, 36'h0);

    // R10: unused codes
    do_rd(3'd6, 14'd10, 1'b1, got);
    check("R10 read code 6 is zero", got, 36'h0);
    do_wr(3'd7, 14'd62, '1, 1'b1);
    do_rd(3'd2, 14'd124, 1'b1, got);
    check("R10 write code 7 ignored", got, 36'hA);

    check("R9 ready stays high", 36'(init_ready), 36'h1);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule